// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block holds a free-running 32-bit tick counter and a 32-bit match register for a processor's control coprocessor. The counter advances by one on every cycle in which the tick-enable input is high. A tick that brings the counter to the match value raises the timer interrupt. The interrupt then stays asserted until software rewrites the match register. Software can load either register through its own write strobe and data bus, and both current values are always visible on read-back outputs.

A freeze input stops the counter and suppresses match events. A 3-bit routing field picks which one of eight interrupt lines carries the timer request. A pending flag is produced for the surrounding cause register, but it is updated only when the architecture-revision input equals 1. The block has no data stream, so all pins are plain control and status signals with no valid/ready handshake: writes take effect on the clock edge where their strobe is sampled high.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the counter reads 1, the match register reads 0, all eight interrupt lines are low and the pending flag is 0.
- R2: When tick-enable is high, freeze is low and no counter write is made, the counter grows by one in the next cycle, and it wraps from 0xFFFFFFFF to 0. Without a tick it holds.
- R3: While freeze is high, the counter keeps its value and no match event is produced, even if a tick would have reached the match value.
- R4: A counter write loads the written value in the next cycle. It takes priority over a tick, it works while frozen, and counting resumes from the loaded value.
- R5: A match-register write loads the written value, which is visible on the read-back output in the next cycle.
- R6: A tick that moves the counter to a value equal to the match register raises the timer interrupt in the same cycle in which the counter shows the new value.
- R7: Once raised, the interrupt stays high until the match register is written or reset is applied. A counter equal to the match value because of a write, not a tick, does not raise it.
- R8: A match-register write drops the interrupt in the next cycle.
- R9: The pending flag is set by a match and cleared by a match-register write only while the revision input equals 1. Otherwise it holds, while the interrupt line behaves as usual.
- R10: The interrupt appears only on line `irq_sel` of `irq_lines` (bit index = `irq_sel`). The other seven lines stay low, and the routing follows `irq_sel` at once.
- R11: When the counter and the match register are written in the same cycle, both values load and no match is flagged in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable for this cycle |
| freeze | input | 1 | Holds the counter and blocks match events |
| rev | input | 3 | Architecture revision; pending flag updates only when 1 |
| irq_sel | input | 3 | Selects the interrupt line that carries the timer request |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 32 | Counter write value |
| cmp_we | input | 1 | Match-register write strobe |
| cmp_wdata | input | 32 | Match-register write value |
| cnt_rd | output | 32 | Current counter value |
| cmp_rd | output | 32 | Current match-register value |
| irq_lines | output | 8 | Interrupt lines, at most one high |
| tmr_pend | output | 1 | Timer pending flag for the cause register |

## Verification
The bench sweeps all eight routing values. For each one it runs a match and checks that only the chosen line rises: a wrong decode would light a neighbour or several lines. It then drives the counter across the 0xFFFFFFFF wrap, freezes the counter one tick short of the match, and writes the counter straight onto the match value. A design that compared without the tick qualifier, or that ignored freeze, would raise the interrupt in those cases. It also writes both registers in one cycle, runs matches with revision values other than 1 (where a careless design would touch the pending flag), and checks that the interrupt stays latched through idle cycles until the next match-register write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned REV_W = 3;
  localparam logic [REV_W-1:0] REV_WITH_PEND = 3'd1;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_inc
);
  assign cnt_inc = cnt_q + W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= RST_VAL;
    else if (we)  cnt_q <= wdata;
    else if (adv) cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/tmr_event.sv
module tmr_event
  import tmr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [W-1:0]     cmp_wdata,
  input  logic [W-1:0]     cnt_inc,
  input  logic [REV_W-1:0] rev,
  output logic [W-1:0]     cmp_q,
  output logic             irq_act,
  output logic             pend_q
);
  logic hit;
  logic pend_upd;

  // a hit needs a real tick and no register write in the same cycle
  assign hit      = adv && !cnt_we && !cmp_we && (cnt_inc == cmp_q);
  assign pend_upd = (rev == REV_WITH_PEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      irq_act <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (cmp_we) begin
        cmp_q   <= cmp_wdata;
        irq_act <= 1'b0;
        if (pend_upd) pend_q <= 1'b0;
      end else if (hit) begin
        irq_act <= 1'b1;
        if (pend_upd) pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_route.sv
module tmr_route #(
  parameter int unsigned N = 8,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic          act,
  input  logic [SW-1:0] sel,
  output logic [N-1:0]  lines
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign lines[i] = act && (sel == SW'(i));
  end
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter int unsigned N = 8,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             freeze,
  input  logic [REV_W-1:0] rev,
  input  logic [SW-1:0]    irq_sel,
  input  logic             cnt_we,
  input  logic [W-1:0]     cnt_wdata,
  input  logic             cmp_we,
  input  logic [W-1:0]     cmp_wdata,
  output logic [W-1:0]     cnt_rd,
  output logic [W-1:0]     cmp_rd,
  output logic [N-1:0]     irq_lines,
  output logic             tmr_pend
);
  logic         adv;
  logic [W-1:0] cnt_inc;
  logic         irq_act;

  assign adv = tick_en && !freeze;

  tmr_count #(.W(W), .RST_VAL(W'(1))) u_count (
    .clk(clk), .rst_n(rst_n), .adv(adv), .we(cnt_we), .wdata(cnt_wdata),
    .cnt_q(cnt_rd), .cnt_inc(cnt_inc)
  );

  tmr_event #(.W(W)) u_event (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cnt_we(cnt_we), .cmp_we(cmp_we),
    .cmp_wdata(cmp_wdata), .cnt_inc(cnt_inc), .rev(rev),
    .cmp_q(cmp_rd), .irq_act(irq_act), .pend_q(tmr_pend)
  );

  tmr_route #(.N(N)) u_route (
    .act(irq_act), .sel(irq_sel), .lines(irq_lines)
  );
endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 8,
  localparam int unsigned SW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          freeze,
  input logic [2:0]    rev,
  input logic          cnt_we,
  input logic [W-1:0]  cnt_wdata,
  input logic          cmp_we,
  input logic [W-1:0]  cmp_wdata,
  input logic [W-1:0]  cnt_rd,
  input logic [W-1:0]  cmp_rd,
  input logic [N-1:0]  irq_lines,
  input logic          tmr_pend
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !freeze && !cnt_we |=> cnt_rd == $past(cnt_rd) + W'(1));
  // R3
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze && !cnt_we |=> $stable(cnt_rd));
  // R4
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_rd == $past(cnt_wdata));
  // R5
  cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> cmp_rd == $past(cmp_wdata));
  // R7
  irq_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines != '0) && !cmp_we |=> irq_lines != '0);
  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> irq_lines == '0);
  // R9
  pend_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rev != 3'd1 |=> $stable(tmr_pend));
  // R10
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));
endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze), .rev(rev),
  .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
  .cnt_rd(cnt_rd), .cmp_rd(cmp_rd), .irq_lines(irq_lines), .tmr_pend(tmr_pend)
);

// File: tb/tick_cmp_timer_bench.sv
module tick_cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, freeze = 1'b0;
  logic [2:0]  rev = 3'd1, irq_sel = 3'd0;
  logic        cnt_we = 1'b0, cmp_we = 1'b0;
  logic [31:0] cnt_wdata = '0, cmp_wdata = '0;
  logic [31:0] cnt_rd, cmp_rd;
  logic [7:0]  irq_lines;
  logic        tmr_pend;

  int tests = 0, fails = 0;
  logic [31:0] m_cnt, m_cmp;
  logic        m_irq, m_pend;

  always #4 clk = ~clk;

  tick_cmp_timer u_tick_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze), .rev(rev),
    .irq_sel(irq_sel), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we),
    .cmp_wdata(cmp_wdata), .cnt_rd(cnt_rd), .cmp_rd(cmp_rd),
    .irq_lines(irq_lines), .tmr_pend(tmr_pend)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "count", cnt_rd, m_cnt);
    chk(tag, "compare", cmp_rd, m_cmp);
    chk(tag, "irq", {24'd0, irq_lines}, m_irq ? (32'd1 << irq_sel) : 32'd0);
    chk(tag, "pend", {31'd0, tmr_pend}, {31'd0, m_pend});
  endtask

  // called at a falling edge: drive, let one rising edge pass, check at next falling edge
  task automatic step(input string tag, input logic tk, input logic fz,
                      input logic kw, input logic [31:0] kd,
                      input logic mw, input logic [31:0] md);
    logic adv, hit;
    tick_en = tk; freeze = fz; cnt_we = kw; cnt_wdata = kd; cmp_we = mw; cmp_wdata = md;
    @(posedge clk);
    adv = tk && !fz;
    hit = adv && !kw && !mw && ((m_cnt + 32'd1) == m_cmp);
    if (mw) begin
      m_cmp = md; m_irq = 1'b0;
      if (rev == 3'd1) m_pend = 1'b0;
    end else if (hit) begin
      m_irq = 1'b1;
      if (rev == 3'd1) m_pend = 1'b1;
    end
    if (kw) m_cnt = kd;
    else if (adv) m_cnt = m_cnt + 32'd1;
    @(negedge clk);
    check_all(tag);
    tick_en = 1'b0; cnt_we = 1'b0; cmp_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_cnt = 32'd1; m_cmp = '0; m_irq = 1'b0; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // R10, R11, R6, R7, R8: sweep every routing value
    for (int s = 0; s < 8; s++) begin
      irq_sel = 3'(s);
      step("R11", 1'b1, 1'b0, 1'b1, 32'd100, 1'b1, 32'd104 + 32'(s));
      for (int k = 0; k < 4 + s; k++) step("R6", 1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
      chk("R10", "line", {24'd0, irq_lines}, 32'd1 << s);
      for (int k = 0; k < 3; k++) step("R7", 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
      step("R7", 1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
      irq_sel = 3'(7 - s);
      @(negedge clk);
      chk("R10", "reroute", {24'd0, irq_lines}, 32'd1 << (7 - s));
      step("R8", 1'b0, 1'b0, 1'b0, '0, 1'b1, 32'hFFFF_0000);
    end

    // R2: wrap and match at zero
    step("R4", 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFE, 1'b1, 32'd0);
    step("R2", 1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
    chk("R2", "no early irq", {24'd0, irq_lines}, 32'd0);
    step("R2", 1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
    chk("R2", "wrap count", cnt_rd, 32'd0);
    step("R5", 1'b1, 1'b0, 1'b0, '0, 1'b1, 32'd50);

    // R3: freeze one tick short of the match
    step("R4", 1'b0, 1'b0, 1'b1, 32'd49, 1'b0, '0);
    for (int k = 0; k < 5; k++) step("R3", 1'b1, 1'b1, 1'b0, '0, 1'b0, '0);
    chk("R3", "no irq", {24'd0, irq_lines}, 32'd0);
    step("R4", 1'b1, 1'b1, 1'b1, 32'd48, 1'b0, '0);
    step("R3", 1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
    step("R3", 1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
    chk("R6", "after thaw", {31'd0, tmr_pend}, 32'd1);
    step("R8", 1'b0, 1'b0, 1'b0, '0, 1'b1, 32'd200);

    // R7: writing the counter onto the match value raises nothing
    step("R7", 1'b1, 1'b0, 1'b1, 32'd200, 1'b0, '0);
    step("R7", 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
    chk("R7", "write-equal", {24'd0, irq_lines}, 32'd0);

    // R9: pending flag under other revisions
    for (int r = 0; r < 8; r++) begin
      rev = 3'(r);
      step("R9", 1'b0, 1'b0, 1'b1, 32'd10, 1'b1, 32'd12);
      step("R9", 1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
      step("R9", 1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
      chk("R9", "irq any rev", {31'd0, |irq_lines}, 32'd1);
    end
    rev = 3'd1;
    step("R9", 1'b0, 1'b0, 1'b0, '0, 1'b1, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule